// File: doc/BRIEF.md
# PHY Initialization Sync Sequencer

This block runs the start-up handshake of a storage-card PHY. Software writes a 32-bit control word that holds four 4-bit duration fields, two plain mode bits and a start bit. Setting the start bit launches a timed sequence on two strobes. First `sync_en` goes high. Then there is a quiet gap, then `sync_rst` goes high. After that comes a settling wait and a fixed tail of eight clocks. When the tail ends, the block clears the start bit, and software polls that bit to learn that the PHY is ready.

All durations are counted in bus clocks. A field of zero removes its phase from the sequence. The durations are captured when the sequence is accepted. Writes made while it runs update the stored word but do not touch the timing already in progress. A write that sets the start bit while the sequence runs does not restart it. The fixed tail stands in for the extra clocks the PHY needs across its own clock domain.

Top module: `phy_init_seq`

## Requirements
- R1: After reset the control word reads 0 and both `sync_en` and `sync_rst` are low.
- R2: Bit 31 of the control word is the start bit. A write with bit 31 set while idle starts a sequence. Bit 31 reads 1 from the clock after that write until the sequence ends, then reads 0 without any further write.
- R3: Bits [11:8] set the length of the sync-enable phase. `sync_en` is high for exactly that many clocks, starting the clock after the accepted start write.
- R4: Bits [7:4] set the gap in clocks between the last `sync_en` clock and the first `sync_rst` clock.
- R5: Bits [3:0] set the number of clocks for which `sync_rst` is high.
- R6: Bits [15:12] set a wait after the sync-reset phase. It is followed by a fixed 8-clock tail in which both strobes are low. Bit 31 therefore reads 1 for (sum of the four fields + 8) clocks.
- R7: A duration field of 0 skips its phase entirely. With all four fields 0, the sequence is only the 8-clock tail.
- R8: A write with bit 31 set while a sequence runs is ignored for sequencing. The running sequence neither restarts nor lengthens, and a write with bit 31 clear does not abort it.
- R9: Writes made during a sequence update the stored fields, which read back with the new values. The running sequence keeps the durations captured at its start.
- R10: Bit 29 (slow mode) and bit 28 (SDIO mode) are plain read/write bits. Bits 30 and 27:16 read 0.
- R11: `sync_en` and `sync_rst` are never high together, and neither is high while bit 31 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Write data for the control word |
| reg_rdata | output | 32 | Current control word, with bit 31 showing sequence busy |
| sync_en | output | 1 | Sync-enable strobe to the PHY |
| sync_rst | output | 1 | Sync-reset strobe to the PHY |

## Verification
The bench goes after zero-length phases, including the case where every field is zero. A design that failed to skip a zero phase would hold a strobe for one clock or sixteen, and the strobe traces and busy length would be off. It rewrites the control word and the start bit mid-sequence. A design that did not latch its durations, or that restarted on the second start, would stretch or reshape the strobes, and the busy window would no longer match the sum of the original fields plus eight. All-maximum fields and a zero gap check the phase boundaries, where an off-by-one counter or overlapping strobes would show up at once.

// File: rtl/phy_init_pkg.sv
package phy_init_pkg;
  localparam int REG_W     = 32;
  localparam int START_BIT = 31;
  localparam int SLOW_BIT  = 29;
  localparam int SDIO_BIT  = 28;
  localparam int NUM_PH    = 4;

  // Timed phases in the order they run; the tail is always last.
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_EN   = 3'd1,
    PH_GAP  = 3'd2,
    PH_RST  = 3'd3,
    PH_WAIT = 3'd4,
    PH_TAIL = 3'd5
  } phase_e;

  // Field slot in the control word for each timed phase index
  // (0 enable, 1 gap, 2 reset, 3 wait). Slot k sits at bits k*FIELD_W.
  function automatic int field_slot(int p);
    case (p)
      0:       return 2;
      1:       return 1;
      2:       return 0;
      default: return 3;
    endcase
  endfunction
endpackage

// File: rtl/pis_ctrl_reg.sv
module pis_ctrl_reg
  import phy_init_pkg::*;
#(
  parameter int FIELD_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr,
  input  logic [REG_W-1:0]          wdata,
  input  logic                      busy,
  output logic [REG_W-1:0]          rdata,
  output logic [NUM_PH*FIELD_W-1:0] fields
);
  localparam int NF = NUM_PH * FIELD_W;

  logic [NF-1:0] fields_q, fields_d;
  logic [1:0]    mode_q, mode_d;
  logic          unused_bits;

  assign unused_bits = ^{wdata[REG_W-2], wdata[SDIO_BIT-1:NF]};

  always_comb begin
    fields_d = fields_q;
    mode_d   = mode_q;
    if (wr) begin
      fields_d = wdata[NF-1:0];
      mode_d   = {wdata[SLOW_BIT], wdata[SDIO_BIT]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fields_q <= '0;
      mode_q   <= '0;
    end else if (wr) begin
      fields_q <= fields_d;
      mode_q   <= mode_d;
    end
  end

  always_comb begin
    rdata            = '0;
    rdata[NF-1:0]    = fields_q;
    rdata[SDIO_BIT]  = mode_q[0];
    rdata[SLOW_BIT]  = mode_q[1];
    rdata[START_BIT] = busy;
  end

  assign fields = fields_q;
endmodule

// File: rtl/pis_phase_pick.sv
module pis_phase_pick
  import phy_init_pkg::*;
#(
  parameter int FIELD_W     = 4,
  parameter int CNT_W       = 4,
  parameter int TAIL_CYCLES = 8
) (
  input  logic [2:0]                       from_ph,
  input  logic [NUM_PH-1:0][FIELD_W-1:0]   lens,
  output phase_e                           ph,
  output logic [CNT_W-1:0]                 load
);
  // First phase at or after from_ph whose length is non-zero; tail otherwise.
  always_comb begin
    ph   = PH_TAIL;
    load = CNT_W'(TAIL_CYCLES - 1);
    for (int i = NUM_PH - 1; i >= 0; i--) begin
      if ((i + 1) >= int'(from_ph) && lens[i] != '0) begin
        ph   = phase_e'(3'(i + 1));
        load = CNT_W'(lens[i]) - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/pis_phase_seq.sv
module pis_phase_seq
  import phy_init_pkg::*;
#(
  parameter int FIELD_W     = 4,
  parameter int TAIL_CYCLES = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_req,
  input  logic [NUM_PH*FIELD_W-1:0] start_fields,
  output logic                      busy,
  output logic                      sync_en,
  output logic                      sync_rst
);
  localparam int CNT_W = ($clog2(TAIL_CYCLES) > FIELD_W) ? $clog2(TAIL_CYCLES) : FIELD_W;

  logic [NUM_PH-1:0][FIELD_W-1:0] new_lens, lat_q, lat_d;
  phase_e                         ph_q, ph_d, first_ph, next_ph;
  logic [CNT_W-1:0]               cnt_q, cnt_d, first_ld, next_ld;
  logic [2:0]                     next_from;
  logic                           idle, accept, state_en;

  for (genvar p = 0; p < NUM_PH; p++) begin : g_map
    assign new_lens[p] = start_fields[field_slot(p)*FIELD_W +: FIELD_W];
  end

  assign next_from = 3'(ph_q) + 3'd1;

  pis_phase_pick #(.FIELD_W(FIELD_W), .CNT_W(CNT_W), .TAIL_CYCLES(TAIL_CYCLES)) u_first (
    .from_ph (3'd1),
    .lens    (new_lens),
    .ph      (first_ph),
    .load    (first_ld)
  );

  pis_phase_pick #(.FIELD_W(FIELD_W), .CNT_W(CNT_W), .TAIL_CYCLES(TAIL_CYCLES)) u_next (
    .from_ph (next_from),
    .lens    (lat_q),
    .ph      (next_ph),
    .load    (next_ld)
  );

  assign idle     = (ph_q == PH_IDLE);
  assign accept   = idle && start_req;
  assign state_en = accept || !idle;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    lat_d = lat_q;
    if (idle) begin
      if (start_req) begin
        ph_d  = first_ph;
        cnt_d = first_ld;
        lat_d = new_lens;
      end
    end else if (cnt_q == '0) begin
      if (ph_q == PH_TAIL) begin
        ph_d = PH_IDLE;
      end else begin
        ph_d  = next_ph;
        cnt_d = next_ld;
      end
    end else begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      lat_q <= '0;
    end else if (state_en) begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      lat_q <= lat_d;
    end
  end

  assign busy     = !idle;
  assign sync_en  = (ph_q == PH_EN);
  assign sync_rst = (ph_q == PH_RST);
endmodule

// File: rtl/phy_init_seq.sv
module phy_init_seq
  import phy_init_pkg::*;
#(
  parameter int FIELD_W     = 4,
  parameter int TAIL_CYCLES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             sync_en,
  output logic             sync_rst
);
  localparam int NF = NUM_PH * FIELD_W;

  logic          busy;
  logic [NF-1:0] stored_fields;
  logic          unused_stored;

  assign unused_stored = ^stored_fields;

  pis_ctrl_reg #(.FIELD_W(FIELD_W)) u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (reg_wr),
    .wdata  (reg_wdata),
    .busy   (busy),
    .rdata  (reg_rdata),
    .fields (stored_fields)
  );

  pis_phase_seq #(.FIELD_W(FIELD_W), .TAIL_CYCLES(TAIL_CYCLES)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_req    (reg_wr && reg_wdata[START_BIT]),
    .start_fields (reg_wdata[NF-1:0]),
    .busy         (busy),
    .sync_en      (sync_en),
    .sync_rst     (sync_rst)
  );
endmodule

// File: rtl/phy_init_seq_chk.sv
module phy_init_seq_chk
  import phy_init_pkg::*;
#(
  parameter int FIELD_W     = 4,
  parameter int TAIL_CYCLES = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [REG_W-1:0] reg_wdata,
  input logic [REG_W-1:0] reg_rdata,
  input logic             sync_en,
  input logic             sync_rst
);
  logic [15:0] run_cnt, exp_len, sum_w;
  logic        start_acc;

  assign start_acc = reg_wr && reg_wdata[START_BIT] && !reg_rdata[START_BIT];

  always_comb begin
    sum_w = 16'(TAIL_CYCLES);
    for (int k = 0; k < NUM_PH; k++) sum_w = sum_w + 16'(reg_wdata[k*FIELD_W +: FIELD_W]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
      exp_len <= '0;
    end else if (start_acc) begin
      run_cnt <= '0;
      exp_len <= sum_w;
    end else if (reg_rdata[START_BIT]) begin
      run_cnt <= run_cnt + 16'd1;
    end
  end

  assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(sync_en && sync_rst));
  assert_strobe_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_en || sync_rst) |-> reg_rdata[START_BIT]);
  assert_busy_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_rdata[START_BIT]) |-> $past(reg_wr && reg_wdata[START_BIT]));
  assert_en_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_en) |-> $past(start_acc));
  assert_run_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reg_rdata[START_BIT]) |-> (run_cnt == exp_len));
  assert_quiet_tail_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reg_rdata[START_BIT]) |-> $past(!sync_en && !sync_rst));
  assert_mode_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> (reg_rdata[SLOW_BIT:SDIO_BIT] == $past(reg_wdata[SLOW_BIT:SDIO_BIT])));
endmodule

bind phy_init_seq phy_init_seq_chk #(.FIELD_W(FIELD_W), .TAIL_CYCLES(TAIL_CYCLES)) u_chk (.*);

// File: tb/phy_init_seq_test.sv
module phy_init_seq_test;
  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        sync_en;
  logic        sync_rst;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  phy_init_seq uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sync_en(sync_en), .sync_rst(sync_rst)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  function automatic int fld(logic [31:0] d, int slot);
    return int'(d[slot*4 +: 4]);
  endfunction
  function automatic int total_len(logic [31:0] d);
    return fld(d, 0) + fld(d, 1) + fld(d, 2) + fld(d, 3) + 8;
  endfunction
  function automatic bit exp_en(logic [31:0] d, int i);
    return i <= fld(d, 2);
  endfunction
  function automatic bit exp_rst(logic [31:0] d, int i);
    int s = fld(d, 2) + fld(d, 1);
    return (i > s) && (i <= s + fld(d, 0));
  endfunction
  function automatic logic [31:0] exp_word(logic [31:0] d);
    return d & 32'h3000_FFFF;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Start a sequence with d; optionally write md during clock mc (0 = none).
  task automatic run_seq(logic [31:0] d, int mc, logic [31:0] md);
    int n = total_len(d);
    int bad_en = 0, bad_rst = 0, bad_busy = 0, overlap = 0;
    reg_wr = 1; reg_wdata = d | 32'h8000_0000;
    @(negedge clk);
    reg_wr = 0;
    for (int i = 1; i <= n + 2; i++) begin
      if (sync_en !== exp_en(d, i)) bad_en++;
      if (sync_rst !== exp_rst(d, i)) bad_rst++;
      if (reg_rdata[31] !== (i <= n)) bad_busy++;
      if (sync_en && sync_rst) overlap++;
      if (i == mc) begin reg_wr = 1; reg_wdata = md; end
      else reg_wr = 0;
      @(negedge clk);
    end
    reg_wr = 0;
    check(bad_en == 0, "R3", "sync_en mismatched clocks", bad_en, 0);
    check(bad_rst == 0, "R4 R5", "sync_rst mismatched clocks", bad_rst, 0);
    check(bad_busy == 0, "R2 R6", "busy-bit mismatched clocks", bad_busy, 0);
    check(overlap == 0, "R11", "overlapping strobe clocks", overlap, 0);
    check(reg_rdata == exp_word(mc != 0 ? md : d), "R9 R10", "readback after run",
          int'(reg_rdata), int'(exp_word(mc != 0 ? md : d)));
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL R2 watchdog expired actual=busy expected=idle");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 0; reg_wr = 0; reg_wdata = '0;
    #23;
    check(reg_rdata == 0 && !sync_en && !sync_rst, "R1", "reset state", int'(reg_rdata), 0);
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(reg_rdata == 0, "R1", "word after reset release", int'(reg_rdata), 0);

    // R10: mode bits and unused bits, no start
    reg_wr = 1; reg_wdata = 32'h7FFF_0000 | 32'h0000_0123;
    @(negedge clk); reg_wr = 0;
    check(reg_rdata == 32'h3000_0123, "R10", "mode bits readback", int'(reg_rdata), 32'h3000_0123);
    check(!sync_en && !sync_rst, "R10", "no strobe without start", int'(sync_en), 0);
    reg_wr = 1; reg_wdata = 32'h1000_0000;
    @(negedge clk); reg_wr = 0;
    check(reg_rdata == 32'h1000_0000, "R10", "slow cleared sdio kept", int'(reg_rdata), 32'h1000_0000);

    // R7: all phases zero, only the tail
    run_seq(32'h0000_0000, 0, 0);
    // R7: enable and reset skipped, gap and wait present
    run_seq(32'h0000_3050, 0, 0);
    // R4: zero gap, reset follows enable directly
    run_seq(32'h0000_0402, 0, 0);
    // maximum everything
    run_seq(32'h2000_FFFF, 0, 0);
    // R8: restart request mid-run ignored
    run_seq(32'h0000_5343, 6, 32'h8000_5343);
    // R8 R9: new fields with start mid-run; sequence keeps old timing
    run_seq(32'h0000_2222, 3, 32'hB000_F1F1);
    // R8: write with start clear mid-run does not abort
    run_seq(32'h0000_4444, 2, 32'h0000_0000);

    for (int t = 0; t < 40; t++) begin
      logic [31:0] d, md;
      int mc;
      d  = $urandom() & 32'h3000_FFFF;
      if (($urandom() % 4) == 0) d[15:0] = d[15:0] & 16'h0F0F;
      md = $urandom();
      mc = (($urandom() % 3) == 0) ? 1 + int'($urandom() % 7) : 0;
      run_seq(d, mc, md);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule